// File: doc/BRIEF.md
# Configurable Port Pin Output Driver Control

This block sits between the port latch of an 8-bit general-purpose I/O port and the pad drivers. For every pin it takes the latch value and a two-bit output mode, and it produces four digital enables for the pad transistors: a pull-down, a strong pull-up, a weak pull-up and a very-weak pull-up. It also returns the pin level, resynchronised into the clock domain, for software readback. The analog pad itself is outside the block, and the resolved pin level comes back in on `pin_i`.

Two mode registers, one for the high mode bit and one for the low mode bit, are loaded through a simple write port. The default mode is quasi-bidirectional. In that mode the pin can be driven low hard, or it can be left high through pull-ups that an external device can overpower. On every rising edge of the latch, a strong pull-up fires for a fixed number of clocks to speed up the low-to-high transition. The three other modes are push-pull, open drain and high-impedance input.

Top module: `port_drive_ctrl`

## Requirements
- R1: After reset both mode registers are zero, so every pin is quasi-bidirectional. The synchronised readback `pin_o` is zero and the strong pull-up is off, even when the latch is 1.
- R2: The mode of pin i is {M1[i], M2[i]}: 00 quasi-bidirectional, 01 push-pull, 10 input only, 11 open drain. A write with `cfg_sel`=0 loads M1 and a write with `cfg_sel`=1 loads M2. The new value is in effect from the clock edge that takes the write. While `cfg_we` is 0 both registers hold, whatever `cfg_wdata` is.
- R3: `pd_en_o[i]` is 1 exactly when the latch bit is 0 and the mode is not input only.
- R4: `vweak_pu_o[i]` is 1 exactly when the mode is quasi-bidirectional and the latch bit is 1.
- R5: `weak_pu_o[i]` is 1 exactly when the mode is quasi-bidirectional, the latch bit is 1 and the synchronised pin level is 1.
- R6: `pin_o` equals `pin_i` delayed by exactly two clock edges.
- R7: In quasi-bidirectional mode, a latch bit that was 0 at one clock edge and is 1 now turns `strong_pu_o[i]` on at once. The enable stays on for that cycle and the next one, which is two clocks in all, and then goes off.
- R8: In push-pull mode the strong pull-up is on for as long as the latch bit is 1. In open-drain and input-only modes no pull-up is ever on.
- R9: A strong pulse stops in the same cycle if the mode leaves quasi-bidirectional or the latch returns to 0. A pulse stopped by a mode change does not resume when the mode returns to quasi-bidirectional.
- R10: On a pin, the pull-down is never on together with any pull-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_sel | input | 1 | Target register: 0 = M1 (high mode bit), 1 = M2 (low mode bit) |
| cfg_wdata | input | 8 | Per-pin mode bits to write |
| latch_i | input | 8 | Port latch value per pin |
| pin_i | input | 8 | Resolved pin level from the pads |
| pd_en_o | output | 8 | Pull-down enable per pin |
| strong_pu_o | output | 8 | Strong pull-up enable per pin |
| weak_pu_o | output | 8 | Weak pull-up enable per pin |
| vweak_pu_o | output | 8 | Very-weak pull-up enable per pin |
| pin_o | output | 8 | Synchronised pin level for readback |

## Verification
The bench measures the length of the strong pulse edge by edge. A pulse that is one clock short or one clock long, that ignores the clock edge on which the latch rises, or that appears after reset with the latch already high shows up as a wrong enable value in a specific cycle. It starts a pulse and then interrupts it, once by switching the pin to input only and once by dropping the latch, and checks that the pulse ends at once and does not resume when quasi mode returns. A design that keeps counting down through a mode change fails here. A sweep over many mode, latch and pin combinations catches swapped encodings, a pull-down left on in input-only mode, and weak gating on the raw pin rather than the synchronised one. A separate stepping test catches a synchroniser with one stage too many or too few.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    typedef enum logic [1:0] {
        MODE_QUASI = 2'b00,
        MODE_PUSH  = 2'b01,
        MODE_HIZ   = 2'b10,
        MODE_OPEN  = 2'b11
    } pin_mode_e;

endpackage

// File: rtl/pdc_mode_regs.sv
module pdc_mode_regs #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             sel,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] m1_o,
    output logic [WIDTH-1:0] m2_o
);

    typedef struct packed {
        logic [WIDTH-1:0] m1;
        logic [WIDTH-1:0] m2;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            if (sel) regs_d.m2 = wdata;
            else     regs_d.m1 = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign m1_o = regs_q.m1;
    assign m2_o = regs_q.m2;

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(m1_o) && $stable(m2_o)));

endmodule

// File: rtl/pdc_sync.sv
module pdc_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] sync_d, sync_q;

    always_comb begin
        sync_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            sync_d[s] = sync_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign q_o = sync_q[STAGES-1];

endmodule

// File: rtl/pdc_pin_cell.sv
module pdc_pin_cell
    import pdc_pkg::*;
#(
    parameter int PULSE_CYCLES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  pin_mode_e mode_i,
    input  logic      latch_i,
    input  logic      pin_s_i,
    output logic      pd_en_o,
    output logic      strong_o,
    output logic      weak_o,
    output logic      vweak_o
);

    localparam int CW = $clog2(PULSE_CYCLES + 1);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
    } cell_t;

    cell_t st_d, st_q;
    logic  is_quasi, is_push, is_hiz, is_open, rise, pulse_on;

    always_comb begin
        is_quasi = (mode_i == MODE_QUASI);
        is_push  = (mode_i == MODE_PUSH);
        is_hiz   = (mode_i == MODE_HIZ);
        is_open  = (mode_i == MODE_OPEN);
        rise     = latch_i && !st_q.prev;
        pulse_on = is_quasi && latch_i && (rise || (st_q.cnt != '0));

        st_d.prev = latch_i;
        if (!is_quasi || !latch_i)  st_d.cnt = '0;
        else if (rise)              st_d.cnt = CW'(PULSE_CYCLES - 1);
        else if (st_q.cnt != '0)    st_d.cnt = st_q.cnt - 1'b1;
        else                        st_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= 1'b1;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pd_en_o  = !latch_i && !is_hiz;
    assign vweak_o  = is_quasi && latch_i;
    assign weak_o   = is_quasi && latch_i && pin_s_i;
    assign strong_o = pulse_on || (is_push && latch_i);

    // pulse length watch: consecutive quasi-mode strong cycles
    logic [CW:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     run_q <= '0;
        else if (!(strong_o && is_quasi)) run_q <= '0;
        else if (run_q <= (CW+1)'(PULSE_CYCLES)) run_q <= run_q + 1'b1;
    end

    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strong_o && is_quasi) |-> (run_q < (CW+1)'(PULSE_CYCLES)));

    // R10
    drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_en_o |-> !(strong_o || weak_o || vweak_o));

    // R3
    hiz_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_hiz |-> !(pd_en_o || strong_o || weak_o || vweak_o));

    // R8
    od_no_pullup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_open |-> !(strong_o || weak_o || vweak_o));

endmodule

// File: rtl/port_drive_ctrl.sv
module port_drive_ctrl
    import pdc_pkg::*;
#(
    parameter int WIDTH        = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int PULSE_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [WIDTH-1:0] cfg_wdata,
    input  logic [WIDTH-1:0] latch_i,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] pd_en_o,
    output logic [WIDTH-1:0] strong_pu_o,
    output logic [WIDTH-1:0] weak_pu_o,
    output logic [WIDTH-1:0] vweak_pu_o,
    output logic [WIDTH-1:0] pin_o
);

    logic [WIDTH-1:0] m1, m2, pin_s;

    pdc_mode_regs #(.WIDTH(WIDTH)) regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .m1_o  (m1),
        .m2_o  (m2)
    );

    pdc_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_s)
    );

    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        pin_mode_e mode;
        assign mode = pin_mode_e'({m1[g], m2[g]});

        pdc_pin_cell #(.PULSE_CYCLES(PULSE_CYCLES)) cell_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode_i   (mode),
            .latch_i  (latch_i[g]),
            .pin_s_i  (pin_s[g]),
            .pd_en_o  (pd_en_o[g]),
            .strong_o (strong_pu_o[g]),
            .weak_o   (weak_pu_o[g]),
            .vweak_o  (vweak_pu_o[g])
        );
    end

    assign pin_o = pin_s;

endmodule

// File: tb/port_drive_ctrl_tb_top.sv
module port_drive_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] latch_i = 8'hFF;
    logic [7:0] pin_i = '0;
    logic [7:0] pd_en_o, strong_pu_o, weak_pu_o, vweak_pu_o, pin_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    port_drive_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .latch_i(latch_i), .pin_i(pin_i),
        .pd_en_o(pd_en_o), .strong_pu_o(strong_pu_o), .weak_pu_o(weak_pu_o),
        .vweak_pu_o(vweak_pu_o), .pin_o(pin_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic check_static(input logic [7:0] m1, input logic [7:0] m2,
                                input logic [7:0] lat, input logic [7:0] pin);
        logic [7:0] quasi, push, hiz;
        quasi = ~m1 & ~m2;
        push  = ~m1 & m2;
        hiz   = m1 & ~m2;
        chk("R3 pulldown",   pd_en_o,     ~lat & ~hiz);
        chk("R4 veryweak",   vweak_pu_o,  quasi & lat);
        chk("R5 weak",       weak_pu_o,   quasi & lat & pin);
        chk("R8 strong",     strong_pu_o, push & lat);
        chk("R6 readback",   pin_o,       pin);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] m1, m2, lat, pin;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state with latch high, pin low
        chk("R1 strong", strong_pu_o, 8'h00);
        chk("R1 vweak",  vweak_pu_o,  8'hFF);
        chk("R1 weak",   weak_pu_o,   8'h00);
        chk("R1 pd",     pd_en_o,     8'h00);
        chk("R1 pin_o",  pin_o,       8'h00);

        // R2 sweep of mode, latch, pin combinations
        for (int k = 0; k < 64; k++) begin
            m1  = 8'(k * 37 + 5);
            m2  = 8'(k * 91 + 3);
            lat = 8'(k * 53 + 17);
            pin = 8'(k * 29 + 11);
            wr(1'b0, m1);
            wr(1'b1, m2);
            latch_i = lat; pin_i = pin;
            repeat (4) @(negedge clk);
            check_static(m1, m2, lat, pin);
        end
        // R2: data without strobe has no effect
        cfg_wdata = ~m1; cfg_sel = 1'b0;
        repeat (2) @(negedge clk);
        cfg_sel = 1'b1; cfg_wdata = ~m2;
        repeat (2) @(negedge clk);
        check_static(m1, m2, lat, pin);

        // all quasi for pulse tests
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h00);
        latch_i = 8'h00; pin_i = 8'h00;
        repeat (4) @(negedge clk);

        // R7 pulse width
        latch_i = 8'h01; #1;
        chk("R7 pulse c0", strong_pu_o, 8'h01);
        @(negedge clk);
        chk("R7 pulse c1", strong_pu_o, 8'h01);
        @(negedge clk);
        chk("R7 pulse c2", strong_pu_o, 8'h00);
        chk("R4 after pulse", vweak_pu_o, 8'h01);

        // R9 cancel by mode change
        latch_i = 8'h00;
        repeat (4) @(negedge clk);
        latch_i = 8'h01; #1;
        chk("R7 rise again", strong_pu_o, 8'h01);
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 8'h01;
        @(negedge clk);
        chk("R9 mode cancel", strong_pu_o, 8'h00);
        chk("R9 hiz vweak",   vweak_pu_o,  8'h00);
        chk("R9 hiz pd",      pd_en_o,     8'hFE);
        cfg_wdata = 8'h00;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R9 no resume", strong_pu_o, 8'h00);
        chk("R9 back quasi", vweak_pu_o, 8'h01);

        // R9 cancel by latch drop
        latch_i = 8'h00;
        repeat (4) @(negedge clk);
        latch_i = 8'h01; #1;
        chk("R7 rise third", strong_pu_o, 8'h01);
        @(negedge clk);
        latch_i = 8'h00; #1;
        chk("R9 latch cancel", strong_pu_o, 8'h00);
        chk("R10 pd on", pd_en_o, 8'hFF);
        @(negedge clk);
        latch_i = 8'h01; #1;
        chk("R7 new pulse", strong_pu_o, 8'h01);
        @(negedge clk);
        chk("R7 new pulse c1", strong_pu_o, 8'h01);
        @(negedge clk);
        chk("R7 new pulse c2", strong_pu_o, 8'h00);

        // R8 push-pull sustained on pin 0
        wr(1'b1, 8'h01);
        repeat (6) @(negedge clk);
        chk("R8 push hold", strong_pu_o, 8'h01);
        wr(1'b1, 8'h00);

        // R6 synchroniser depth and R5 weak gating
        latch_i = 8'hFF; pin_i = 8'h00;
        repeat (4) @(negedge clk);
        pin_i = 8'hA5; #1;
        chk("R6 stage0", pin_o, 8'h00);
        chk("R5 raw pin ignored", weak_pu_o, 8'h00);
        @(negedge clk);
        chk("R6 stage1", pin_o, 8'h00);
        @(negedge clk);
        chk("R6 stage2", pin_o, 8'hA5);
        chk("R5 weak synced", weak_pu_o, 8'hA5);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule